// File: doc/BRIEF.md
# Lock Status Interrupt Controller

This block collects live loss-of-lock indications from two PLLs, plus any other status sources wired to the same vector, and presents them to software through a small register port. Each live bit has a sticky companion. The sticky bit latches on the rising edge of its live bit and holds until software clears it by writing 0 to it.

A per-bit mask decides which sticky events may pull the active-low interrupt output. The interrupt stays low while any unmasked sticky event is pending.

The block also provides one self-clearing soft-reset control bit per PLL. Writing 1 to such a bit produces a single-cycle reset pulse on the matching output, and the bit always reads back as 0. Lock detection itself happens outside the block.

Top module: `lock_irq_ctrl`

## Requirements
- R1: After a synchronous reset all sticky bits and all mask bits are 0, `irq_n` is 1 and both `pll_rst` bits are 0.
- R2: A read of address 0 returns the live status vector as sampled one clock earlier. A bit reads 1 while its source reports loss of lock, with PLL A at bit 5 and PLL B at bit 6.
- R3: A sticky bit (read at address 1) is set in the cycle after its live bit rises from 0 to 1. It stays set after the live bit falls. A live bit that remains high does not set the sticky bit again once it has been cleared.
- R4: Writing to address 1 clears every sticky bit whose data bit is 0. Sticky bits whose data bit is 1 are left unchanged.
- R5: When a rising live bit and a clearing write to the same sticky bit fall in the same cycle, the sticky bit ends up set.
- R6: Address 2 holds the mask and reads back what was written. A mask bit of 1 keeps its sticky event from driving `irq_n`, and a mask bit of 0 lets it through.
- R7: `irq_n` is 0 exactly when, one cycle earlier, some sticky bit was set with its mask bit at 0. Otherwise it is 1.
- R8: Writing to address 3 with data bit 0 (PLL A) or bit 1 (PLL B) at 1 drives the matching `pll_rst` bit high for exactly one cycle. A read of address 3 always returns 0.
- R9: Reads have one cycle of latency. `rd_data` is registered and holds the selected register's value in the cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select: 0 live, 1 sticky, 2 mask, 3 soft reset |
| wr_data | input | STAT_W | Write data |
| rd_data | output | STAT_W | Registered read data |
| status_in | input | STAT_W | Live status inputs, 1 = unlocked |
| irq_n | output | 1 | Active-low interrupt |
| pll_rst | output | NUM_PLL | Single-cycle soft-reset pulses, bit 0 = PLL A |

## Verification
A wrong sticky state appears at the ports within two cycles. It shows on `irq_n` one cycle after the sticky bit changes, and on the sticky read-back one cycle after the read strobe. The bench therefore reads back sticky and mask after every stimulus and watches `irq_n` two cycles later. A faulty set/clear priority or a missing edge detector shows up in the same-cycle collision test and in the held-high test as a sticky bit with the wrong value. A soft-reset pulse that is too long or is stored in the register shows up as a `pll_rst` bit still high one cycle later, or as a nonzero read of address 3.

// File: rtl/lsic_pkg.sv
package lsic_pkg;
  typedef enum logic [1:0] {
    SEL_LIVE   = 2'd0,
    SEL_STICKY = 2'd1,
    SEL_MASK   = 2'd2,
    SEL_SRST   = 2'd3
  } reg_sel_e;

  localparam int PLL_A_LOL_BIT = 5;
  localparam int PLL_B_LOL_BIT = 6;
endpackage

// File: rtl/lsic_sticky_bank.sv
module lsic_sticky_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] live_in,
  input  logic         clr_we,
  input  logic [W-1:0] clr_data,
  output logic [W-1:0] live_q,
  output logic [W-1:0] sticky_q
);
  logic [W-1:0] sticky_nxt;

  // Per bit: a rising live edge sets, a written 0 clears, and set has priority.
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic rise;
    logic clr;
    assign rise          = live_in[i] & ~live_q[i];
    assign clr           = clr_we & ~clr_data[i];
    assign sticky_nxt[i] = rise | (sticky_q[i] & ~clr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q   <= '0;
      sticky_q <= '0;
    end else begin
      live_q   <= live_in;
      sticky_q <= sticky_nxt;
    end
  end
endmodule

// File: rtl/lsic_irq_gen.sv
module lsic_irq_gen #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mask_we,
  input  logic [W-1:0] mask_data,
  input  logic [W-1:0] sticky,
  output logic [W-1:0] mask_q,
  output logic         irq_n
);
  logic pending;
  assign pending = |(sticky & ~mask_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      irq_n  <= 1'b1;
    end else begin
      if (mask_we) mask_q <= mask_data;
      irq_n <= ~pending;
    end
  end
endmodule

// File: rtl/lsic_soft_reset.sv
module lsic_soft_reset #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [N-1:0] data,
  output logic [N-1:0] pulse
);
  always_ff @(posedge clk) begin
    if (rst) pulse <= '0;
    else     pulse <= we ? data : '0;
  end
endmodule

// File: rtl/lock_irq_ctrl.sv
module lock_irq_ctrl
  import lsic_pkg::*;
#(
  parameter int STAT_W  = 8,
  parameter int NUM_PLL = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [1:0]         addr,
  input  logic [STAT_W-1:0]  wr_data,
  output logic [STAT_W-1:0]  rd_data,
  input  logic [STAT_W-1:0]  status_in,
  output logic               irq_n,
  output logic [NUM_PLL-1:0] pll_rst
);
  logic [STAT_W-1:0] status_q;
  logic [STAT_W-1:0] sticky_q;
  logic [STAT_W-1:0] mask_q;
  logic              we_sticky;
  logic              we_mask;
  logic              we_srst;
  logic [STAT_W-1:0] rd_mux;

  assign we_sticky = wr_en && (addr == SEL_STICKY);
  assign we_mask   = wr_en && (addr == SEL_MASK);
  assign we_srst   = wr_en && (addr == SEL_SRST);

  lsic_sticky_bank #(.W(STAT_W)) u_sticky (
    .clk      (clk),
    .rst      (rst),
    .live_in  (status_in),
    .clr_we   (we_sticky),
    .clr_data (wr_data),
    .live_q   (status_q),
    .sticky_q (sticky_q)
  );

  lsic_irq_gen #(.W(STAT_W)) u_irq (
    .clk       (clk),
    .rst       (rst),
    .mask_we   (we_mask),
    .mask_data (wr_data),
    .sticky    (sticky_q),
    .mask_q    (mask_q),
    .irq_n     (irq_n)
  );

  lsic_soft_reset #(.N(NUM_PLL)) u_srst (
    .clk   (clk),
    .rst   (rst),
    .we    (we_srst),
    .data  (wr_data[NUM_PLL-1:0]),
    .pulse (pll_rst)
  );

  always_comb begin
    case (addr)
      SEL_LIVE:   rd_mux = status_q;
      SEL_STICKY: rd_mux = sticky_q;
      SEL_MASK:   rd_mux = mask_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end
endmodule

// File: rtl/lock_irq_ctrl_chk.sv
module lock_irq_ctrl_chk #(
  parameter int STAT_W  = 8,
  parameter int NUM_PLL = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic               rd_en,
  input logic [1:0]         addr,
  input logic [STAT_W-1:0]  wr_data,
  input logic [STAT_W-1:0]  rd_data,
  input logic [STAT_W-1:0]  status_in,
  input logic [STAT_W-1:0]  status_q,
  input logic [STAT_W-1:0]  sticky_q,
  input logic [STAT_W-1:0]  mask_q,
  input logic               irq_n,
  input logic [NUM_PLL-1:0] pll_rst
);
  assert_rise_sets_R3: assert property (@(posedge clk) disable iff (rst)
    (|(status_in & ~status_q)) |=>
      ((sticky_q & $past(status_in & ~status_q)) == $past(status_in & ~status_q)));

  assert_sticky_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == 2'd1) |=> ((~sticky_q & $past(sticky_q)) == '0));

  assert_irq_follows_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_n == ~|($past(sticky_q & ~mask_q))));

  assert_pulse_source_R8: assert property (@(posedge clk) disable iff (rst)
    pll_rst[0] |-> $past(wr_en && addr == 2'd3 && wr_data[0]));

  assert_srst_reads_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 2'd3) |=> (rd_data == '0));
endmodule

bind lock_irq_ctrl lock_irq_ctrl_chk #(.STAT_W(STAT_W), .NUM_PLL(NUM_PLL)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .addr      (addr),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .status_in (status_in),
  .status_q  (status_q),
  .sticky_q  (sticky_q),
  .mask_q    (mask_q),
  .irq_n     (irq_n),
  .pll_rst   (pll_rst)
);

// File: tb/lock_irq_ctrl_test.sv
module lock_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [7:0] status_in = 8'h00;
  logic       irq_n;
  logic [1:0] pll_rst;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic rd_pend = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  lock_irq_ctrl uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .status_in(status_in),
    .irq_n(irq_n), .pll_rst(pll_rst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: compares each read result in the cycle after its strobe (R9).
  always @(posedge clk) rd_pend <= rd_en;
  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) begin
      automatic logic [7:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      chk(t, {24'h0, rd_data}, {24'h0, e});
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Driver: issues a read and queues the value the requirements predict.
  task automatic rd_expect(input logic [1:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: reset state
    chk("R1 irq_n", {31'h0, irq_n}, 1);
    chk("R1 pll_rst", {30'h0, pll_rst}, 0);
    rd_expect(2'd1, 8'h00, "R1 sticky");
    rd_expect(2'd2, 8'h00, "R1 mask");

    // R2/R3: PLL A (bit 5) loses lock
    status_in = 8'h20;
    idle(1);
    rd_expect(2'd0, 8'h20, "R2 live A");
    chk("R7 irq low on A", {31'h0, irq_n}, 0);
    rd_expect(2'd1, 8'h20, "R3 sticky A set");
    status_in = 8'h00;
    idle(2);
    rd_expect(2'd0, 8'h00, "R2 live relock");
    rd_expect(2'd1, 8'h20, "R3 sticky holds");

    // R4: writing 1 keeps, writing 0 clears
    wr(2'd1, 8'hFF);
    rd_expect(2'd1, 8'h20, "R4 write ones keep");
    wr(2'd1, 8'hDF);
    rd_expect(2'd1, 8'h00, "R4 write zero clears");
    chk("R7 irq released", {31'h0, irq_n}, 1);

    // R6: masked PLL B event (bit 6)
    wr(2'd2, 8'h40);
    status_in = 8'h40;
    idle(3);
    chk("R6 masked no irq", {31'h0, irq_n}, 1);
    rd_expect(2'd1, 8'h40, "R3 sticky B set");
    rd_expect(2'd2, 8'h40, "R6 mask readback");
    wr(2'd2, 8'h00);
    idle(1);
    chk("R6 unmask irq low", {31'h0, irq_n}, 0);

    // R5: set and clear collide, set wins; B is cleared by same write
    status_in = 8'h00;
    idle(2);
    @(negedge clk);
    status_in = 8'h20; wr_en = 1'b1; addr = 2'd1; wr_data = 8'h00;
    @(negedge clk);
    wr_en = 1'b0;
    rd_expect(2'd1, 8'h20, "R5 set wins");

    // R3: level held high does not re-set after clear
    wr(2'd1, 8'h00);
    idle(2);
    rd_expect(2'd1, 8'h00, "R3 no reset while held");
    chk("R7 irq high none pending", {31'h0, irq_n}, 1);

    // R6/R7: masking a pending event releases irq
    status_in = 8'h00;
    idle(1);
    status_in = 8'h21;
    idle(3);
    chk("R7 two events irq", {31'h0, irq_n}, 0);
    wr(2'd2, 8'h20);
    idle(1);
    chk("R7 one unmasked still low", {31'h0, irq_n}, 0);
    wr(2'd2, 8'h21);
    idle(1);
    chk("R6 all masked irq high", {31'h0, irq_n}, 1);

    // R8: soft reset pulses
    wr(2'd3, 8'h01);
    chk("R8 pulse A", {30'h0, pll_rst}, 32'h1);
    idle(1);
    chk("R8 pulse A ends", {30'h0, pll_rst}, 0);
    wr(2'd3, 8'h02);
    chk("R8 pulse B", {30'h0, pll_rst}, 32'h2);
    idle(1);
    chk("R8 pulse B ends", {30'h0, pll_rst}, 0);
    wr(2'd3, 8'h03);
    chk("R8 pulse both", {30'h0, pll_rst}, 32'h3);
    rd_expect(2'd3, 8'h00, "R8 srst reads zero");
    chk("R8 both ended", {30'h0, pll_rst}, 0);

    idle(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule